// File: doc/BRIEF.md
# Stacked Register Frame Mapper

This block is the integer register file of a core whose upper registers form a procedure stack. It converts each logical register number into a physical index and then reads or writes a 128-entry, 64-bit register array. It has two read ports and one write port. The low 32 logical registers are global. They reach the same physical entry whatever procedure is running. The upper 96 logical registers are private to the current procedure. They are relocated by a frame base and bounded by a frame size. The base and size together are the current frame.

A call gives the callee a fresh frame of the requested size. That frame sits directly above the caller's frame, and the caller's base and size are saved on a small internal stack. A return restores the most recent saved frame. The block does not spill registers to memory. When a call cannot be accepted, it raises a flag and leaves all state unchanged. Accesses outside the current frame are flagged and have no effect.

Top module: `regstack_mapper`

## Requirements
- R1: Logical registers 0 to 31 map to physical entries 0 to 31 on every port, whatever the current frame, and never raise an illegal flag.
- R2: A logical register r of 32 or more, with r-32 below the frame size, maps to physical entry 32 + ((base + r - 32) mod 96).
- R3: A logical register r of 32 or more, with r-32 at or above the frame size, is illegal. A read of it returns zero and raises that read port's illegal flag. A write to it changes no entry and raises the write illegal flag.
- R4: An accepted call with requested size s takes effect at the next clock edge. The new base is (old base + old size) mod 96, the new size is s, and the old base and size are saved.
- R5: A return restores the most recently saved base and size at the next clock edge. A return with no saved frame raises the return error flag in that cycle and leaves the frame unchanged.
- R6: A call is refused, with the overflow flag raised in that cycle and the frame unchanged, when the sizes of the current frame, all saved frames and the requested frame together exceed 96. A call is also refused when 8 frames are already saved.
- R7: When call and return are requested in the same cycle, the call is performed and the return is ignored.
- R8: After reset, all 128 entries hold zero, the base and size are zero, and no frame is saved.
- R9: A write becomes visible at the clock edge that ends its cycle. A read of the same entry in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Request a new frame |
| call_size_i | input | 7 | Size of the requested frame |
| ret_i | input | 1 | Return to the saved frame |
| rd_a_idx_i | input | 7 | Logical index, read port A |
| rd_a_data_o | output | 64 | Data, read port A |
| rd_a_illegal_o | output | 1 | Port A index is outside the frame |
| rd_b_idx_i | input | 7 | Logical index, read port B |
| rd_b_data_o | output | 64 | Data, read port B |
| rd_b_illegal_o | output | 1 | Port B index is outside the frame |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 7 | Logical index, write port |
| wr_data_i | input | 64 | Write data |
| wr_illegal_o | output | 1 | Write index is outside the frame |
| call_ovf_o | output | 1 | Call refused (no room or saved-frame stack full) |
| ret_err_o | output | 1 | Return with no saved frame |

## Verification
The bench keeps its own model of the frame base, the frame size and the stack of saved frames. It compares every port on every cycle.

- **Stacked register mapping.** It nests calls and then reads the caller's registers back after the returns. A design that relocated stacked registers wrongly would show the caller's values overwritten by the callee's writes.
- **Frame boundary.** It probes the first index past the frame on both read ports and on the write port. An off-by-one bound would either return stale data or let a stray write corrupt a live register.
- **Overflow.** It fills the 96 stacked registers exactly and then asks for one more. An overflow check that was off by one would either refuse the exact fit or accept the overrun.
- **Saved-frame stack.** It drives the saved-frame stack to its depth of 8 and then empties it. A depth bug would miss the ninth-call refusal or the error on a return with nothing saved.
- **Call and return together.** It issues a call and a return in the same cycle. A design with the wrong priority would show the wrong frame in the cycles that follow.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
   typedef enum logic [1:0] {
      FOP_IDLE = 2'd0,
      FOP_CALL = 2'd1,
      FOP_RET  = 2'd2
   } frame_op_e;
endpackage

// File: rtl/regstack_frame_ctl.sv
module regstack_frame_ctl
   import regstack_pkg::*;
#(
   parameter int NSTACKED = 96,
   parameter int SDEPTH   = 8,
   parameter int FW       = $clog2(NSTACKED + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          call_i,
   input  logic [FW-1:0] call_size_i,
   input  logic          ret_i,
   output logic [FW-1:0] base_o,
   output logic [FW-1:0] size_o,
   output logic          ovf_o,
   output logic          ret_err_o
);
   localparam int DW = $clog2(SDEPTH + 1);
   localparam int PW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1;
   localparam int UW = FW + 1;

   frame_op_e         op;
   logic [FW-1:0]     base_q, size_q, used_q;
   logic [DW-1:0]     depth_q;
   logic [FW-1:0]     sv_base [SDEPTH];
   logic [FW-1:0]     sv_size [SDEPTH];
   logic              full, empty, too_big;
   logic [UW-1:0]     need, nb_sum;
   logic [FW-1:0]     next_base;
   logic [PW-1:0]     push_ptr, pop_ptr;

   always_comb begin
      if (call_i)     op = FOP_CALL;
      else if (ret_i) op = FOP_RET;
      else            op = FOP_IDLE;
   end

   assign full      = (depth_q == DW'(SDEPTH));
   assign empty     = (depth_q == '0);
   assign need      = UW'(used_q) + UW'(call_size_i);
   assign too_big   = (need > UW'(NSTACKED));
   assign ovf_o     = (op == FOP_CALL) && (full || too_big);
   assign ret_err_o = (op == FOP_RET) && empty;
   assign nb_sum    = UW'(base_q) + UW'(size_q);
   assign next_base = (nb_sum >= UW'(NSTACKED)) ? FW'(nb_sum - UW'(NSTACKED)) : FW'(nb_sum);
   assign push_ptr  = PW'(depth_q);
   assign pop_ptr   = PW'(depth_q - DW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         size_q  <= '0;
         used_q  <= '0;
         depth_q <= '0;
         for (int i = 0; i < SDEPTH; i++) begin
            sv_base[i] <= '0;
            sv_size[i] <= '0;
         end
      end else begin
         case (op)
            FOP_CALL: if (!ovf_o) begin
               sv_base[push_ptr] <= base_q;
               sv_size[push_ptr] <= size_q;
               depth_q <= depth_q + DW'(1);
               base_q  <= next_base;
               size_q  <= call_size_i;
               used_q  <= FW'(need);
            end
            FOP_RET: if (!empty) begin
               base_q  <= sv_base[pop_ptr];
               size_q  <= sv_size[pop_ptr];
               used_q  <= used_q - size_q;
               depth_q <= depth_q - DW'(1);
            end
            default: ;
         endcase
      end
   end

   assign base_o = base_q;
   assign size_o = size_q;

   assert_used_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= FW'(NSTACKED));
   assert_ovf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ($stable(base_o) && $stable(size_o)));
   assert_ret_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err_o |=> ($stable(base_o) && $stable(size_o)));
   assert_call_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ovf_o) |=> (size_o == $past(call_size_i)));
   assert_call_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i) |-> !ret_err_o);
endmodule

// File: rtl/regstack_xlate.sv
module regstack_xlate #(
   parameter int NREG     = 128,
   parameter int NSTATIC  = 32,
   parameter int NSTACKED = NREG - NSTATIC,
   parameter int FW       = $clog2(NSTACKED + 1),
   parameter int IW       = $clog2(NREG)
) (
   input  logic [IW-1:0] idx_i,
   input  logic [FW-1:0] base_i,
   input  logic [FW-1:0] size_i,
   output logic [IW-1:0] phys_o,
   output logic          illegal_o
);
   localparam int SW = ((IW > FW) ? IW : FW) + 2;

   logic [SW-1:0] idx_w, off, sum, wrapped;
   logic          stacked;

   assign idx_w     = SW'(idx_i);
   assign stacked   = (idx_w >= SW'(NSTATIC));
   assign off       = idx_w - SW'(NSTATIC);
   assign sum       = SW'(base_i) + off;
   assign wrapped   = (sum >= SW'(NSTACKED)) ? (sum - SW'(NSTACKED)) : sum;
   assign illegal_o = stacked && (off >= SW'(size_i));
   assign phys_o    = stacked ? IW'(wrapped + SW'(NSTATIC)) : idx_i;
endmodule

// File: rtl/regstack_rf.sv
module regstack_rf #(
   parameter int NREG = 128,
   parameter int XLEN = 64,
   parameter int NRD  = 2,
   parameter int IW   = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NRD-1:0][IW-1:0]    rd_idx_i,
   output logic [NRD-1:0][XLEN-1:0]  rd_data_o,
   input  logic                      we_i,
   input  logic [IW-1:0]             wr_idx_i,
   input  logic [XLEN-1:0]           wr_data_i
);
   logic [XLEN-1:0] mem [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[wr_idx_i] <= wr_data_i;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data_o[g] = mem[rd_idx_i[g]];
   end
endmodule

// File: rtl/regstack_mapper.sv
module regstack_mapper #(
   parameter int NREG     = 128,
   parameter int NSTATIC  = 32,
   parameter int XLEN     = 64,
   parameter int SDEPTH   = 8,
   parameter int NSTACKED = NREG - NSTATIC,
   parameter int FW       = $clog2(NSTACKED + 1),
   parameter int IW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic [FW-1:0]   call_size_i,
   input  logic            ret_i,
   input  logic [IW-1:0]   rd_a_idx_i,
   output logic [XLEN-1:0] rd_a_data_o,
   output logic            rd_a_illegal_o,
   input  logic [IW-1:0]   rd_b_idx_i,
   output logic [XLEN-1:0] rd_b_data_o,
   output logic            rd_b_illegal_o,
   input  logic            wr_en_i,
   input  logic [IW-1:0]   wr_idx_i,
   input  logic [XLEN-1:0] wr_data_i,
   output logic            wr_illegal_o,
   output logic            call_ovf_o,
   output logic            ret_err_o
);
   localparam int NRD = 2;

   if (NSTATIC >= NREG) begin : g_bad_split
      $error("static region must leave stacked registers");
   end
   if (SDEPTH < 1) begin : g_bad_depth
      $error("saved-frame stack needs at least one entry");
   end
   if (NREG != (1 << IW)) begin : g_bad_nreg
      $error("register count must be a power of two");
   end

   logic [FW-1:0]              base, size;
   logic [NRD-1:0][IW-1:0]     lg_idx, ph_idx;
   logic [NRD-1:0][XLEN-1:0]   rf_data, rd_data;
   logic [NRD-1:0]             rd_ill;
   logic [IW-1:0]              wr_phys;

   regstack_frame_ctl #(.NSTACKED(NSTACKED), .SDEPTH(SDEPTH), .FW(FW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_size_i(call_size_i),
      .ret_i(ret_i), .base_o(base), .size_o(size),
      .ovf_o(call_ovf_o), .ret_err_o(ret_err_o));

   assign lg_idx[0] = rd_a_idx_i;
   assign lg_idx[1] = rd_b_idx_i;

   for (genvar g = 0; g < NRD; g++) begin : g_rport
      regstack_xlate #(.NREG(NREG), .NSTATIC(NSTATIC), .NSTACKED(NSTACKED),
                       .FW(FW), .IW(IW)) u_xl (
         .idx_i(lg_idx[g]), .base_i(base), .size_i(size),
         .phys_o(ph_idx[g]), .illegal_o(rd_ill[g]));
      assign rd_data[g] = rd_ill[g] ? '0 : rf_data[g];

      assert_rd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         rd_ill[g] |-> (rd_data[g] == '0));
      assert_static_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (lg_idx[g] < IW'(NSTATIC)) |-> !rd_ill[g]);
   end

   regstack_xlate #(.NREG(NREG), .NSTATIC(NSTATIC), .NSTACKED(NSTACKED),
                    .FW(FW), .IW(IW)) u_wxl (
      .idx_i(wr_idx_i), .base_i(base), .size_i(size),
      .phys_o(wr_phys), .illegal_o(wr_illegal_o));

   regstack_rf #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD), .IW(IW)) u_rf (
      .clk(clk), .rst_n(rst_n), .rd_idx_i(ph_idx), .rd_data_o(rf_data),
      .we_i(wr_en_i && !wr_illegal_o), .wr_idx_i(wr_phys), .wr_data_i(wr_data_i));

   assign rd_a_data_o    = rd_data[0];
   assign rd_b_data_o    = rd_data[1];
   assign rd_a_illegal_o = rd_ill[0];
   assign rd_b_illegal_o = rd_ill[1];

   assert_stacked_phys_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_ill[0] && (rd_a_idx_i >= IW'(NSTATIC))) |-> (ph_idx[0] >= IW'(NSTATIC)));
endmodule

// File: tb/regstack_mapper_bench.sv
`timescale 1ns/1ps
module regstack_mapper_bench;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            call_i, ret_i, wr_en_i;
   logic [6:0]      call_size_i, rd_a_idx_i, rd_b_idx_i, wr_idx_i;
   logic [XLEN-1:0] wr_data_i, rd_a_data_o, rd_b_data_o;
   logic            rd_a_illegal_o, rd_b_illegal_o, wr_illegal_o, call_ovf_o, ret_err_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   longint unsigned m_mem [128];
   int m_base, m_size, m_used;
   int sv_base[$], sv_size[$];

   always #2.5 clk = ~clk;

   regstack_mapper u_regstack_mapper (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_size_i(call_size_i),
      .ret_i(ret_i), .rd_a_idx_i(rd_a_idx_i), .rd_a_data_o(rd_a_data_o),
      .rd_a_illegal_o(rd_a_illegal_o), .rd_b_idx_i(rd_b_idx_i),
      .rd_b_data_o(rd_b_data_o), .rd_b_illegal_o(rd_b_illegal_o),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .wr_illegal_o(wr_illegal_o), .call_ovf_o(call_ovf_o), .ret_err_o(ret_err_o));

   task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void mapx(input int idx, output int phys, output bit ill, output string tag);
      ill = 0;
      if (idx < 32) begin phys = idx; tag = "R1"; end
      else if (idx - 32 >= m_size) begin phys = 0; ill = 1; tag = "R3"; end
      else begin phys = 32 + ((m_base + idx - 32) % 96); tag = "R2"; end
   endfunction

   task automatic cyc(input bit c, input int cs, input bit r, input int ra, input int rb,
                      input bit we, input int wi, input longint unsigned wd);
      int pa, pb, pw;
      bit ia, ib, iw, ovf, rerr;
      string ta, tb, tw;
      @(negedge clk);
      call_i = c; call_size_i = 7'(cs); ret_i = r;
      rd_a_idx_i = 7'(ra); rd_b_idx_i = 7'(rb);
      wr_en_i = we; wr_idx_i = 7'(wi); wr_data_i = wd;
      #1;
      mapx(ra, pa, ia, ta);
      mapx(rb, pb, ib, tb);
      mapx(wi, pw, iw, tw);
      check({ta, " rd_a data"}, rd_a_data_o, ia ? 64'd0 : m_mem[pa]);
      check({ta, " rd_a illegal"}, 64'(rd_a_illegal_o), 64'(ia));
      check({tb, " rd_b data"}, rd_b_data_o, ib ? 64'd0 : m_mem[pb]);
      check({tb, " rd_b illegal"}, 64'(rd_b_illegal_o), 64'(ib));
      check({tw, " wr illegal"}, 64'(wr_illegal_o), 64'(iw));
      ovf  = c && (sv_base.size() == 8 || m_used + cs > 96);
      rerr = !c && r && sv_base.size() == 0;    // R7: call takes priority
      check("R6 overflow flag", 64'(call_ovf_o), 64'(ovf));
      check("R5 return error", 64'(ret_err_o), 64'(rerr));
      @(posedge clk);
      if (we && !iw) m_mem[pw] = wd;            // R9: visible after this edge
      if (c && !ovf) begin                      // R4
         sv_base.push_back(m_base); sv_size.push_back(m_size);
         m_base = (m_base + m_size) % 96; m_size = cs; m_used += cs;
      end else if (!c && r && !rerr) begin      // R5
         m_used -= m_size;
         m_base = sv_base.pop_back(); m_size = sv_size.pop_back();
      end
   endtask

   task automatic idle_rd(input int ra, input int rb);
      cyc(0, 0, 0, ra, rb, 0, 0, 0);
   endtask

   task automatic wr(input int wi, input longint unsigned wd);
      cyc(0, 0, 0, wi, 0, 1, wi, wd);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; call_i = 0; ret_i = 0; wr_en_i = 0;
      call_size_i = 0; rd_a_idx_i = 0; rd_b_idx_i = 0; wr_idx_i = 0; wr_data_i = 0;
      repeat (3) @(posedge clk);
      foreach (m_mem[i]) m_mem[i] = 0;
      m_base = 0; m_size = 0; m_used = 0;
      sv_base.delete(); sv_size.delete();
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R8: cleared state, no frame, stacked access illegal
      idle_rd(5, 32);
      idle_rd(31, 127);
      // R1: globals written and read back
      for (int i = 0; i < 32; i++) wr(i, 64'hA5A5_0000_0000_0000 | 64'(i));
      for (int i = 0; i < 32; i += 2) idle_rd(i, i + 1);
      // R4: first frame, size 10
      cyc(1, 10, 0, 32, 3, 0, 0, 0);
      for (int i = 32; i < 42; i++) wr(i, 64'h1000 + 64'(i));
      for (int i = 32; i < 42; i += 2) idle_rd(i, i + 1);
      // R3: one past the frame on all ports
      cyc(0, 0, 0, 42, 41, 1, 42, 64'hDEAD);
      cyc(0, 0, 0, 42, 100, 1, 45, 64'hBEEF);
      // R2: nested frame of 20 relocated above the caller
      cyc(1, 20, 0, 33, 52, 0, 0, 0);
      for (int i = 32; i < 52; i++) wr(i, 64'h2000 + 64'(i));
      for (int i = 32; i < 52; i += 2) idle_rd(i, i + 1);
      idle_rd(52, 0);
      // R9: write and read the same register in one cycle
      cyc(0, 0, 0, 40, 40, 1, 40, 64'h5555);
      idle_rd(40, 40);
      // R7: call and return together, call wins
      cyc(1, 5, 1, 32, 36, 0, 0, 0);
      wr(32, 64'h3000);
      idle_rd(32, 37);
      // R5: unwind to the first frame, its data intact
      cyc(0, 0, 1, 32, 33, 0, 0, 0);
      cyc(0, 0, 1, 40, 50, 0, 0, 0);
      for (int i = 32; i < 42; i += 2) idle_rd(i, i + 1);
      // R6: exact fill then overrun by one
      cyc(1, 60, 0, 0, 0, 0, 0, 0);      // used 70
      cyc(1, 27, 0, 0, 0, 0, 0, 0);      // 97: refused
      idle_rd(32, 91);
      cyc(1, 26, 0, 0, 0, 0, 0, 0);      // 96: accepted
      wr(57, 64'h7777);
      idle_rd(57, 58);
      cyc(1, 0, 0, 0, 0, 0, 0, 0);       // zero-size still fits
      cyc(1, 1, 0, 0, 0, 0, 0, 0);       // refused
      // R5: pop everything, then one return too many
      for (int k = 0; k < 4; k++) cyc(0, 0, 1, 32, 33, 0, 0, 0);
      cyc(0, 0, 1, 32, 0, 0, 0, 0);
      idle_rd(32, 5);
      // R6: saved-frame stack depth of eight
      for (int k = 0; k < 8; k++) cyc(1, 1, 0, 32, 33, 0, 0, 0);
      cyc(1, 1, 0, 32, 0, 0, 0, 0);      // ninth: refused
      wr(32, 64'h9999);
      idle_rd(32, 33);
      for (int k = 0; k < 9; k++) cyc(0, 0, 1, 32, 33, 0, 0, 0);
      // R8: reset clears contents and frames again
      do_reset();
      idle_rd(0, 32);
      idle_rd(7, 31);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule